// File: doc/BRIEF.md
# Ready/Valid Queue with Pipe and Flow Options

This block is a synchronous first-in first-out buffer. It has a ready/valid handshake on the producer side and another on the consumer side. The producer offers a word with `enqValid`. The queue takes the word in any cycle where `enqReady` is also high. The consumer sees the oldest stored word on `deqData` while `deqValid` is high, and removes it by raising `deqReady`. A `count` output gives the number of words held at the moment.

Two elaboration-time switches change the handshake at the two extremes of occupancy:

- **PIPE.** A full queue keeps `enqReady` high whenever the consumer is ready. One word leaves and one enters in the same cycle, so a chain of depth-one stages runs at full rate.
- **FLOW.** An empty queue shows an arriving word on its output in the same cycle. If the consumer takes that word at once, it never enters storage and the count stays at zero.

`DEPTH` and `DATA_W` are parameters, and a depth of one is supported with either option.

Top module: `rv_queue`

## Requirements
- R1: A word moves across either side only in a cycle where that side's valid and ready are both high. A word offered while `enqReady` is low is not stored.
- R2: Words appear on `deqData` in the order they were accepted, each exactly once, with none lost.
- R3: Without PIPE, `enqReady` is high exactly when `count` is below `DEPTH`. With PIPE, `enqReady` is always high below `DEPTH`.
- R4: Without FLOW, `deqValid` is high exactly when `count` is non-zero. With FLOW, `deqValid` is always high when `count` is non-zero.
- R5: `count` equals the words accepted minus the words delivered since reset. It never exceeds `DEPTH`, and it is `$clog2(DEPTH+1)` bits wide so that it can hold `DEPTH`.
- R6: With PIPE and a full queue, `enqReady` follows `deqReady` in the same cycle, so a new word is stored in the cycle the head leaves.
- R7: The PIPE behaviour of R6 holds for `DEPTH` = 1.
- R8: With FLOW and an empty queue, an offered word raises `deqValid` and appears on `deqData` in the same cycle.
- R9: With FLOW, a word that bypasses an empty queue and is taken in the same cycle leaves `count` at zero in the next cycle.
- R10: A synchronous active-high `rst` empties the queue: after it, `count` is 0, `enqReady` is 1, and `deqValid` is 0 while `enqValid` is low.
- R11: While `deqValid` is high, `deqReady` is low and the queue holds at least one word, `deqData` stays the same in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enqValid | input | 1 | Producer offers `enqData` |
| enqReady | output | 1 | Queue can take a word this cycle |
| enqData | input | DATA_W | Word offered by the producer |
| deqValid | output | 1 | `deqData` holds a word for the consumer |
| deqReady | input | 1 | Consumer takes `deqData` this cycle |
| deqData | output | DATA_W | Oldest word, or the bypassed word in FLOW mode |
| count | output | $clog2(DEPTH+1) | Current occupancy |

## Verification
A wrong pointer or a wrong full flag shows first on `count`. It also shows on the ready/valid pair, within the same cycle as the bad state. A slot that is written but never read, or read twice, shows only as a wrong or repeated word on `deqData`. That happens when the word reaches the head, which can be up to `DEPTH` deliveries later. For this reason the reference queue compares every delivered word, as well as the handshake and the count, on every cycle. A bypass that wrongly writes storage breaks `count` in the next cycle.

// File: rtl/rv_queue_pkg.sv
package rv_queue_pkg;

  // Strobes sent from the control to the storage each cycle.
  typedef struct packed {
    logic wrEn;       // write enqData into the slot at the write pointer
    logic useBypass;  // drive deqData straight from enqData
  } rvqStrobe_t;

endpackage

// File: rtl/rv_queue_ctrl.sv
module rv_queue_ctrl
  import rv_queue_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter bit PIPE  = 1'b0,
  parameter bit FLOW  = 1'b0,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enqValid,
  input  logic             deqReady,
  output logic             enqReady,
  output logic             deqValid,
  output logic [CNT_W-1:0] count,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output rvqStrobe_t       strobe
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic full;
  logic empty;
  logic enqFire;
  logic deqFire;
  logic rdEn;
  int   occ;

  function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    empty            = (wrPtr == rdPtr) && !full;
    enqReady         = !full || (PIPE && deqReady);
    deqValid         = !empty || (FLOW && enqValid);
    enqFire          = enqValid && enqReady;
    deqFire          = deqValid && deqReady;
    strobe.useBypass = FLOW && empty;
    strobe.wrEn      = enqFire && !(FLOW && empty && deqReady);
    rdEn             = deqFire && !empty;
  end

  always_comb begin
    occ = int'(wrPtr) - int'(rdPtr);
    if (occ < 0) occ = occ + DEPTH;
    if (full) occ = DEPTH;
    count = CNT_W'(occ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      full  <= 1'b0;
    end else begin
      if (strobe.wrEn) wrPtr <= advance(wrPtr);
      if (rdEn)        rdPtr <= advance(rdPtr);
      if (strobe.wrEn && !rdEn)      full <= (advance(wrPtr) == rdPtr);
      else if (rdEn && !strobe.wrEn) full <= 1'b0;
    end
  end

endmodule

// File: rtl/rv_queue_store.sv
module rv_queue_store
  import rv_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk,
  input  rvqStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  input  logic [DATA_W-1:0] enqData,
  output logic [DATA_W-1:0] deqData
);

  logic [DATA_W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) slots[wrPtr] <= enqData;
  end

  assign deqData = strobe.useBypass ? enqData : slots[rdPtr];

endmodule

// File: rtl/rv_queue.sv
module rv_queue
  import rv_queue_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit PIPE   = 1'b0,
  parameter bit FLOW   = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       enqValid,
  output logic                       enqReady,
  input  logic [DATA_W-1:0]          enqData,
  output logic                       deqValid,
  input  logic                       deqReady,
  output logic [DATA_W-1:0]          deqData,
  output logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  rvqStrobe_t       strobe;

  rv_queue_ctrl #(
    .DEPTH(DEPTH), .PIPE(PIPE), .FLOW(FLOW), .PTR_W(PTR_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .enqValid(enqValid), .deqReady(deqReady),
    .enqReady(enqReady), .deqValid(deqValid), .count(count),
    .wrPtr(wrPtr), .rdPtr(rdPtr), .strobe(strobe)
  );

  rv_queue_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
  ) u_store (
    .clk(clk), .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .enqData(enqData), .deqData(deqData)
  );

endmodule

// File: rtl/rv_queue_chk.sv
module rv_queue_chk #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  parameter bit PIPE   = 1'b0,
  parameter bit FLOW   = 1'b0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       enqValid,
  input logic                       enqReady,
  input logic [DATA_W-1:0]          enqData,
  input logic                       deqValid,
  input logic                       deqReady,
  input logic [DATA_W-1:0]          deqData,
  input logic [$clog2(DEPTH+1)-1:0] count
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic enqFire;
  logic deqFire;
  assign enqFire = enqValid && enqReady;
  assign deqFire = deqValid && deqReady;

  // R3
  room_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (count != FULL_CNT) |-> enqReady);

  // R3
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!PIPE && count == FULL_CNT) |-> !enqReady);

  // R4
  data_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> deqValid);

  // R4
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!FLOW && count == '0) |-> !deqValid);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    enqValid |-> (count <= FULL_CNT));

  // R5
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (enqFire || deqFire) |=>
      (int'(count) == int'($past(count)) + int'($past(enqFire)) - int'($past(deqFire))));

  // R1
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(enqFire || deqFire) |=> $stable(count));

  // R6
  pipe_swap_chk: assert property (@(posedge clk) disable iff (rst)
    (PIPE && count == FULL_CNT && deqReady) |-> enqReady);

  // R8
  flow_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (FLOW && count == '0 && enqValid) |-> (deqValid && deqData == enqData));

  // R9
  flow_nostore_chk: assert property (@(posedge clk) disable iff (rst)
    (FLOW && count == '0 && enqValid && deqReady) |=> (count == '0));

  // R11
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (deqValid && !deqReady && count != '0) |=> $stable(deqData));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (count == '0));

endmodule

bind rv_queue rv_queue_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .PIPE(PIPE), .FLOW(FLOW)
) u_chk (
  .clk(clk), .rst(rst), .enqValid(enqValid), .enqReady(enqReady),
  .enqData(enqData), .deqValid(deqValid), .deqReady(deqReady),
  .deqData(deqData), .count(count)
);

// File: tb/tb_rv_queue.sv
`timescale 1ns/1ps
module tb_rv_queue;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Four instances: plain, pipe, pipe with depth 1, flow.
  logic       evA, erA, dvA, drA;  logic [7:0] edA, ddA;  logic [2:0] cA;
  logic       evB, erB, dvB, drB;  logic [7:0] edB, ddB;  logic [2:0] cB;
  logic       evC, erC, dvC, drC;  logic [7:0] edC, ddC;  logic       cC;
  logic       evD, erD, dvD, drD;  logic [7:0] edD, ddD;  logic [2:0] cD;

  rv_queue #(.DATA_W(8), .DEPTH(4), .PIPE(1'b0), .FLOW(1'b0)) dut (
    .clk(clk), .rst(rst), .enqValid(evA), .enqReady(erA), .enqData(edA),
    .deqValid(dvA), .deqReady(drA), .deqData(ddA), .count(cA));
  rv_queue #(.DATA_W(8), .DEPTH(4), .PIPE(1'b1), .FLOW(1'b0)) dutPipe (
    .clk(clk), .rst(rst), .enqValid(evB), .enqReady(erB), .enqData(edB),
    .deqValid(dvB), .deqReady(drB), .deqData(ddB), .count(cB));
  rv_queue #(.DATA_W(8), .DEPTH(1), .PIPE(1'b1), .FLOW(1'b0)) dutPipe1 (
    .clk(clk), .rst(rst), .enqValid(evC), .enqReady(erC), .enqData(edC),
    .deqValid(dvC), .deqReady(drC), .deqData(ddC), .count(cC));
  rv_queue #(.DATA_W(8), .DEPTH(4), .PIPE(1'b0), .FLOW(1'b1)) dutFlow (
    .clk(clk), .rst(rst), .enqValid(evD), .enqReady(erD), .enqData(edD),
    .deqValid(dvD), .deqReady(drD), .deqData(ddD), .count(cD));

  int qA[$], qB[$], qC[$], qD[$];
  bit bpA, bpB, bpC, bpD;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference step: compare outputs with the behavioural queue, then apply the fires.
  task automatic step(input string nm, input int depth, input bit pipe, input bit flow,
                      input bit ev, input bit dr, input int ed,
                      input bit erAct, input bit dvAct, input int ddAct, input int cntAct,
                      ref int q[$], ref bit lastBp);
    int  n;
    bit  expEr, expDv, ef, df, bypass;
    n      = q.size();
    expEr  = (n < depth) || (pipe && dr);
    expDv  = (n > 0) || (flow && ev);
    bypass = flow && (n == 0) && ev && dr;
    chk(lastBp ? "R9" : "R5", {nm, " count"}, cntAct, n);
    chk(pipe ? ((depth == 1) ? "R7" : "R6") : "R3", {nm, " enqReady"}, int'(erAct), int'(expEr));
    chk((flow && n == 0) ? "R8" : "R4", {nm, " deqValid"}, int'(dvAct), int'(expDv));
    if (expDv)
      chk((n == 0) ? "R8" : "R1/R2/R11", {nm, " deqData"}, ddAct, (n > 0) ? q[0] : ed);
    ef = ev && expEr;
    df = expDv && dr;
    if (df && n > 0) void'(q.pop_front());
    if (ef && !bypass) q.push_back(ed);
    lastBp = bypass;
  endtask

  task automatic resetChecks();
    chk("R10", "plain count",    int'(cA), 0);
    chk("R10", "plain deqValid", int'(dvA), 0);
    chk("R10", "plain enqReady", int'(erA), 1);
    chk("R10", "pipe count",     int'(cB), 0);
    chk("R10", "pipe1 count",    int'(cC), 0);
    chk("R10", "pipe1 deqValid", int'(dvC), 0);
    chk("R10", "flow count",     int'(cD), 0);
    chk("R10", "flow deqValid",  int'(dvD), 0);
  endtask

  task automatic idleInputs();
    evA = 0; drA = 0; edA = '0;  evB = 0; drB = 0; edB = '0;
    evC = 0; drC = 0; edC = '0;  evD = 0; drD = 0; edD = '0;
  endtask

  task automatic clearModels();
    qA.delete(); qB.delete(); qC.delete(); qD.delete();
    bpA = 0; bpB = 0; bpC = 0; bpD = 0;
  endtask

  function automatic bit pick(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin
    int pe, pr;
    idleInputs();
    clearModels();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 resetChecks();
    for (int cyc = 0; cyc < 4000; cyc++) begin
      case ((cyc / 250) % 4)
        0:       begin pe = 90; pr = 20; end  // producer heavy: reach full
        1:       begin pe = 20; pr = 90; end  // consumer heavy: reach empty
        2:       begin pe = 50; pr = 50; end
        default: begin pe = 95; pr = 95; end  // back-to-back swaps and bypasses
      endcase
      if (cyc == 2100) begin
        // Reset while the queues hold data (R10).
        @(negedge clk);
        rst = 1'b1;
        idleInputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clearModels();
        #1 resetChecks();
      end
      @(negedge clk);
      evA = pick(pe); drA = pick(pr); edA = 8'($urandom);
      evB = pick(pe); drB = pick(pr); edB = 8'($urandom);
      evC = pick(pe); drC = pick(pr); edC = 8'($urandom);
      evD = pick(pe); drD = pick(pr); edD = 8'($urandom);
      #1;
      step("plain", 4, 1'b0, 1'b0, evA, drA, int'(edA), erA, dvA, int'(ddA), int'(cA), qA, bpA);
      step("pipe",  4, 1'b1, 1'b0, evB, drB, int'(edB), erB, dvB, int'(ddB), int'(cB), qB, bpB);
      step("pipe1", 1, 1'b1, 1'b0, evC, drC, int'(edC), erC, dvC, int'(ddC), int'(cC), qC, bpC);
      step("flow",  4, 1'b0, 1'b1, evD, drD, int'(edD), erD, dvD, int'(ddD), int'(cD), qD, bpD);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule